// File: doc/BRIEF.md
# Windowed Register Access Sequencer

This block sits on the host side of a link whose memory aperture is only 1 MB wide, yet the target exposes a 32 MB register space. A client hands it one 32-bit read or write at a time, addressed by a flat 25-bit byte offset. The block turns that request into one to three transactions on a simple master port toward the aperture.

Offsets in the lower half of the aperture, and every offset while windowing is switched off, go straight through. Higher offsets need a window register inside the aperture to select which 512 KB slice of target space appears in the aperture's upper half. The block first writes that register and then reads it back to confirm the value. After that it performs the data access inside the upper half.

The block keeps the last window value it wrote. It skips the program-and-confirm pair when the next windowed access falls in the same slice, unless a configuration input demands that the pair run on every windowed access. A confirmation mismatch raises a sticky error flag, and the data access still goes ahead.

Top module: `win_access_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `m_valid` and `err_win` are all 0.
- R2: With windowing enabled, an offset below 0x80000 produces exactly one master transaction, at aperture address offset[19:0], and no window register traffic.
- R3: With `cfg_win_en` low, every offset, high ones included, produces exactly one master transaction at aperture address offset[19:0], and the cached window is left unchanged.
- R4: A windowed access that needs programming first issues a master write to aperture address 0x310C with data (1 << 30) | offset[24:19].
- R5: The window write is followed at once by a master read of 0x310C. If the read data differs from the written word, `err_win` goes to 1 and stays 1 until reset, and the data access still takes place.
- R6: The data transaction of a windowed access targets aperture address 0x80000 | offset[18:0], with the client's write flag and write data.
- R7: With `cfg_force_prog` low, a windowed access whose window equals the last window written produces only the data transaction.
- R8: With `cfg_force_prog` high, every windowed access produces the write and read of 0x310C, even when the window is unchanged.
- R9: Reset invalidates the cached window, so the first windowed access after reset programs the register whatever its window value.
- R10: A request is taken when `req_valid` and `req_ready` are both high. `req_ready` stays low until the single-cycle `rsp_valid` pulse has been given. `rsp_rdata` carries the read data, or 0 for a write.
- R11: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_write`, `m_addr` and `m_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_win_en | input | 1 | Enables window translation of high offsets |
| cfg_force_prog | input | 1 | Programs the window on every windowed access |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 25 | Flat target byte offset |
| req_wdata | input | 32 | Client write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| err_win | output | 1 | Sticky window confirmation error |
| m_valid | output | 1 | Master transaction present |
| m_ready | input | 1 | Aperture completes the transaction this cycle |
| m_write | output | 1 | Master write flag |
| m_addr | output | 20 | Aperture byte address |
| m_wdata | output | 32 | Master write data |
| m_rdata | input | 32 | Aperture read data, valid with m_ready |

## Verification
The bench replays window hits, misses and the first access after a reset. A design with a broken cache would either emit a stray write to 0x310C or leave it out, and the scoreboard shows both as an unexpected or missing transaction. Disabled-windowing accesses to high offsets are checked for a truncated direct address and an untouched cache, so a design that translated them, or refreshed its cache from them, shows a wrong address or a wrong hit later on. A corrupted confirmation read must set a flag that survives later clean accesses while the data access still runs, and the aperture stalls on a fixed pattern so that a master port dropping its request shows up as a lost or doubled transaction.

// File: rtl/win_seq_pkg.sv
package win_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WIN_WR,
        ST_WIN_RB,
        ST_DATA,
        ST_RESP
    } seq_state_e;
endpackage

// File: rtl/win_addr_map.sv
module win_addr_map #(
    parameter int unsigned OFS_W     = 25,
    parameter int unsigned BAR_AW    = 20,
    parameter int unsigned WIN_SHIFT = 19,
    parameter int unsigned WIN_W     = 6
) (
    input  logic [OFS_W-1:0]  ofs,
    input  logic              win_en,
    output logic              direct,
    output logic [WIN_W-1:0]  win,
    output logic [BAR_AW-1:0] bar_addr
);
    localparam logic [BAR_AW-1:0] WIN_BASE = BAR_AW'(1) << WIN_SHIFT;

    logic low_ofs;

    always_comb begin
        low_ofs  = (ofs[OFS_W-1:WIN_SHIFT] == '0);
        direct   = !win_en || low_ofs;
        win      = ofs[WIN_SHIFT +: WIN_W];
        bar_addr = direct ? ofs[BAR_AW-1:0]
                          : (WIN_BASE | BAR_AW'(ofs[WIN_SHIFT-1:0]));
    end
endmodule

// File: rtl/win_cache.sv
module win_cache #(
    parameter int unsigned WIN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIN_W-1:0] load_val,
    input  logic [WIN_W-1:0] cmp_val,
    output logic             hit
);
    typedef struct packed {
        logic             valid;
        logic [WIN_W-1:0] val;
    } cache_t;

    cache_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (load) begin
            c_d.valid = 1'b1;
            c_d.val   = load_val;
        end
        hit = c_q.valid && (c_q.val == cmp_val);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    // R9
    cache_reset_miss_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> !hit);
endmodule

// File: rtl/win_access_seq.sv
module win_access_seq
    import win_seq_pkg::*;
#(
    parameter int unsigned OFS_W        = 25,
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned BAR_AW       = 20,
    parameter int unsigned WIN_SHIFT    = 19,
    parameter int unsigned WIN_W        = 6,
    parameter int unsigned WIN_REG_OFS  = 'h310C,
    parameter int unsigned EN_BIT       = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_win_en,
    input  logic              cfg_force_prog,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              err_win,
    output logic              m_valid,
    input  logic              m_ready,
    output logic              m_write,
    output logic [BAR_AW-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    input  logic [DATA_W-1:0] m_rdata
);
    localparam logic [BAR_AW-1:0] WIN_REG  = BAR_AW'(WIN_REG_OFS);
    localparam logic [DATA_W-1:0] EN_MASK  = DATA_W'(1) << EN_BIT;

    typedef struct packed {
        seq_state_e        state;
        logic              is_write;
        logic [DATA_W-1:0] wdata;
        logic [BAR_AW-1:0] bar_addr;
        logic [WIN_W-1:0]  win;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic              map_direct;
    logic [WIN_W-1:0]  map_win;
    logic [BAR_AW-1:0] map_addr;
    logic              cache_hit;
    logic              cache_load;
    logic [DATA_W-1:0] win_word;

    win_addr_map #(
        .OFS_W(OFS_W), .BAR_AW(BAR_AW), .WIN_SHIFT(WIN_SHIFT), .WIN_W(WIN_W)
    ) u_map (
        .ofs(req_offset), .win_en(cfg_win_en),
        .direct(map_direct), .win(map_win), .bar_addr(map_addr)
    );

    win_cache #(.WIN_W(WIN_W)) u_cache (
        .clk(clk), .rst_n(rst_n),
        .load(cache_load), .load_val(r_q.win),
        .cmp_val(map_win), .hit(cache_hit)
    );

    always_comb begin
        r_d        = r_q;
        win_word   = EN_MASK | DATA_W'(r_q.win);
        m_valid    = 1'b0;
        m_write    = 1'b0;
        m_addr     = r_q.bar_addr;
        m_wdata    = r_q.wdata;
        cache_load = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.is_write = req_write;
                    r_d.wdata    = req_wdata;
                    r_d.bar_addr = map_addr;
                    r_d.win      = map_win;
                    r_d.rdata    = '0;
                    if (map_direct || (cache_hit && !cfg_force_prog))
                        r_d.state = ST_DATA;
                    else
                        r_d.state = ST_WIN_WR;
                end
            end
            ST_WIN_WR: begin
                m_valid = 1'b1;
                m_write = 1'b1;
                m_addr  = WIN_REG;
                m_wdata = win_word;
                if (m_ready) begin
                    cache_load = 1'b1;
                    r_d.state  = ST_WIN_RB;
                end
            end
            ST_WIN_RB: begin
                m_valid = 1'b1;
                m_addr  = WIN_REG;
                if (m_ready) begin
                    if (m_rdata != win_word) r_d.err = 1'b1;
                    r_d.state = ST_DATA;
                end
            end
            ST_DATA: begin
                m_valid = 1'b1;
                m_write = r_q.is_write;
                if (m_ready) begin
                    if (!r_q.is_write) r_d.rdata = m_rdata;
                    r_d.state = ST_RESP;
                end
            end
            ST_RESP: r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.state == ST_IDLE);
    assign rsp_valid = (r_q.state == ST_RESP);
    assign rsp_rdata = r_q.rdata;
    assign err_win   = r_q.err;

    // R11
    m_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_wdata));

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready);

    // R10
    ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_win |=> err_win);

    // R4
    win_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && m_write && m_addr == WIN_REG && !req_ready
            |-> m_wdata[EN_BIT]);

    // R5
    rb_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && m_ready && m_write && m_addr == WIN_REG
            |=> m_valid && !m_write && m_addr == WIN_REG);
endmodule

// File: tb/win_access_seq_tb.sv
module win_access_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_win_en = 1'b1;
    logic        cfg_force_prog = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [24:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        err_win;
    logic        m_valid;
    logic        m_ready = 1'b0;
    logic        m_write;
    logic [19:0] m_addr;
    logic [31:0] m_wdata;
    logic [31:0] m_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rsp_cnt = 0;
    bit stall_mode = 0;
    bit corrupt = 0;
    bit finished = 0;

    logic [31:0] mem [logic [19:0]];

    typedef struct {
        logic        wr;
        logic [19:0] addr;
        logic [31:0] data;
    } txn_t;

    txn_t        exp_q[$];
    string       tag_q[$];
    logic [31:0] rsp_q[$];
    string       rtag_q[$];

    bit       mc_valid = 0;
    bit [5:0] mc_win = '0;

    always #10 clk = ~clk;

    win_access_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_win_en(cfg_win_en), .cfg_force_prog(cfg_force_prog),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_offset(req_offset), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_win(err_win),
        .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata)
    );

    function automatic logic [31:0] peek(input logic [19:0] a);
        if (mem.exists(a)) return mem[a];
        return {12'hD00, a};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // aperture model and scoreboard monitor
    always @(negedge clk) begin
        cyc++;
        m_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
        m_rdata = peek(m_addr) ^ ((corrupt && m_addr == 20'h0310C) ? 32'h1 : 32'h0);
        if (rst_n && m_valid && m_ready) begin
            if (exp_q.size() == 0) begin
                check(0, "R2 unexpected master txn", {11'h0, m_write, m_addr}, 32'h0);
            end else begin
                txn_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(m_write == e.wr, {t, " write flag"}, {31'h0, m_write}, {31'h0, e.wr});
                check(m_addr == e.addr, {t, " address"}, {12'h0, m_addr}, {12'h0, e.addr});
                if (e.wr) check(m_wdata == e.data, {t, " write data"}, m_wdata, e.data);
            end
            if (m_write) mem[m_addr] = m_wdata;
        end
        if (rst_n && rsp_valid) begin
            rsp_cnt++;
            if (rsp_q.size() == 0) begin
                check(0, "R10 unexpected response", rsp_rdata, 32'h0);
            end else begin
                logic [31:0] er;
                string       t;
                er = rsp_q.pop_front();
                t  = rtag_q.pop_front();
                check(rsp_rdata == er, {t, " response data"}, rsp_rdata, er);
            end
        end
    end

    task automatic access(input logic wr, input logic [24:0] ofs,
                          input logic [31:0] wd, input string tag);
        bit          direct;
        logic [5:0]  win;
        logic [19:0] bar;
        txn_t        t;
        int          start;
        int          waited;
        direct = !cfg_win_en || (ofs < 25'h80000);
        win    = ofs[24:19];
        bar    = direct ? ofs[19:0] : (20'h80000 | {1'b0, ofs[18:0]});
        if (!direct && (cfg_force_prog || !mc_valid || mc_win != win)) begin
            t.wr = 1; t.addr = 20'h0310C; t.data = 32'h4000_0000 | {26'h0, win};
            exp_q.push_back(t); tag_q.push_back({tag, " window write (R4)"});
            t.wr = 0; t.addr = 20'h0310C; t.data = '0;
            exp_q.push_back(t); tag_q.push_back({tag, " window readback (R5)"});
            mc_valid = 1; mc_win = win;
        end
        t.wr = wr; t.addr = bar; t.data = wd;
        exp_q.push_back(t); tag_q.push_back({tag, " data access"});
        rsp_q.push_back(wr ? 32'h0 : peek(bar)); rtag_q.push_back({tag, " (R10)"});
        start = rsp_cnt;
        @(negedge clk);
        req_write = wr; req_offset = ofs; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        waited = 0;
        while (rsp_cnt == start && waited < 60) begin
            @(negedge clk);
            waited++;
        end
        check(rsp_cnt != start, {tag, " response seen (R10)"}, rsp_cnt, start + 1);
        check(exp_q.size() == 0, {tag, " all txns seen"}, exp_q.size(), 0);
        exp_q.delete(); tag_q.delete(); rsp_q.delete(); rtag_q.delete();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        check(m_valid == 1'b0, "R1 m_valid", m_valid, 0);
        check(err_win == 1'b0, "R1 err_win", err_win, 0);
        rst_n = 1'b1;
        mc_valid = 0;
    endtask

    initial begin
        do_reset();
        // R2 low offsets go direct
        access(0, 25'h0000120, '0, "R2 low read");
        access(1, 25'h007FFFC, 32'hCAFE0001, "R2 low write");
        access(0, 25'h007FFFC, '0, "R2 low readback");
        // R9 first windowed access after reset programs; R4 R6
        access(0, 25'h0A12344, '0, "R9 first window");
        // R7 hit skips programming
        access(1, 25'h0A00010, 32'h1234_5678, "R7 hit write");
        access(0, 25'h0A00010, '0, "R7 hit read");
        // R6 new window, top of space, with stalls (R11)
        stall_mode = 1;
        access(1, 25'h1FFFFFC, 32'hA5A5_5A5A, "R6 top write");
        access(0, 25'h1FFFFFC, '0, "R6 top read");
        access(0, 25'h0080000, '0, "R6 window one");
        stall_mode = 0;
        // R3 disabled windowing: direct, cache untouched
        cfg_win_en = 0;
        access(0, 25'h1234567, '0, "R3 disabled read");
        access(1, 25'h0F80100, 32'h0BAD_F00D, "R3 disabled write");
        cfg_win_en = 1;
        access(0, 25'h0080040, '0, "R3 cache kept");
        // R8 forced programming
        cfg_force_prog = 1;
        access(0, 25'h0080040, '0, "R8 forced one");
        access(0, 25'h0080044, '0, "R8 forced two");
        cfg_force_prog = 0;
        // R5 mismatch flags error, data still proceeds
        check(err_win == 1'b0, "R5 err clear before", err_win, 0);
        corrupt = 1;
        access(0, 25'h0300008, '0, "R5 corrupt readback");
        corrupt = 0;
        check(err_win == 1'b1, "R5 err set", err_win, 1);
        access(0, 25'h0000008, '0, "R5 later access");
        check(err_win == 1'b1, "R5 err sticky", err_win, 1);
        // R9 reset clears error and invalidates cache
        do_reset();
        access(0, 25'h0300008, '0, "R9 after reset");
        check(err_win == 1'b0, "R9 err after reset", err_win, 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule